// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a word-addressed scratchpad split into parallel banks. It takes one group of lane requests at a time over a valid/ready handshake. Each lane brings an enable, a word address, a write flag and write data. The low address bits pick the bank and the upper bits pick the word within that bank. Lanes whose banks differ are all served in the same cycle. Lanes that land in one bank are served one after another, lowest lane first. The one exception is a group in which every enabled lane presents the same address: that group is served in a single broadcast cycle. When the group is finished the block pulses `done`. At that point it presents every lane's read word and the number of service cycles the group used.

The control is a three-state machine:
- **IDLE**: `req_ready` is high. A handshake captures the group. IDLE goes to **ISSUE** when any lane is enabled, and straight to **FINISH** when no lane is enabled.
- **ISSUE**: each bank serves its chosen lane or lanes, and their pending bits are cleared. ISSUE stays in ISSUE while lanes remain pending. It moves to FINISH on the cycle that serves the last pending lanes.
- **FINISH**: lets the final bank read land in the lane registers, then returns to IDLE. On the return, `done` is raised for one cycle.

Top module: `bank_conflict_serializer`

## Requirements
- R1: The bank of a lane is its word address modulo NUM_BANKS, which is the low 4 bits by default. The remaining upper bits select the word inside that bank. Lanes whose low bits differ never collide, whatever their upper bits are.
- R2: A group is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the acceptance edge until the group finishes. Input changes while the block is busy do not affect the group in flight.
- R3: A group whose enabled lanes all map to different banks takes one service cycle (`rsp_cycles` = 1).
- R4: When lanes share a bank, `rsp_cycles` equals the largest number of enabled lanes in any one bank. Within a bank, lanes are served in ascending lane order, so a higher lane reading a word sees a write made to that word by a lower lane of the same group.
- R5: When every enabled lane presents one identical address, the group takes one cycle. Every enabled lane receives the word as it was before the group, and the data of the highest-numbered writing lane is stored.
- R6: Disabled lanes never count toward conflicts, and their `rsp_rdata` slot reads zero. A group with no enabled lane reports `rsp_cycles` = 0.
- R7: `done` is a one-cycle pulse. It is high in the cycle that follows exactly `rsp_cycles`+1 clock edges after the acceptance edge.
- R8: Each served lane returns the content of its word from before its own write in that cycle (read-first). Lane i's word is in bits [32*i+31:32*i] of `rsp_rdata`.
- R9: For lane addresses base + s*lane, an odd stride s needs one cycle, stride 2 needs two cycles, stride 4 needs four, and stride 16 needs sixteen.
- R10: After reset `req_ready` is high, `done` is low, `rsp_cycles` is zero and every `rsp_rdata` word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A group is offered |
| req_ready | output | 1 | Block is idle and can take a group |
| req_lane_en | input | NUM_LANES | Per-lane enable |
| req_addr | input | NUM_LANES*ADDR_W | Word address of each lane, lane i in slice i |
| req_wr | input | NUM_LANES | Per-lane write flag |
| req_wdata | input | NUM_LANES*DATA_W | Write data of each lane |
| done | output | 1 | One-cycle pulse when the group's results are valid |
| rsp_rdata | output | NUM_LANES*DATA_W | Read word of each lane, held until the next group is accepted |
| rsp_cycles | output | CNT_W | Number of service cycles the last group used |

## Verification
The bench goes after the cases where a wrong serializer still looks plausible.

- A broadcast group with writers must hand every lane the old word and keep the highest writer. A design that serialized that group would instead return sixteen cycles and newer data to the higher lanes.
- A lower-lane write followed by a higher-lane read of the same word in one bank must be visible to the reader. An arbiter that picked the highest lane first would return the stale word.
- Strided and upper-bit-only address patterns expose a bank hash that uses the wrong bits, because they report the wrong cycle count.
- Empty groups and groups with disabled lanes parked in a busy bank catch a design that lets disabled lanes add conflicts or leak stale read data.
- Random collision-heavy groups, checked for latency, pulse width and every lane's word, catch an off-by-one in the completion path.

// File: rtl/scb_pkg.sv
package scb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } sched_state_t;

endpackage

// File: rtl/scb_bank.sv
// One scratchpad bank: synchronous, read-first, single port.
module scb_bank #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 6
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            rdata <= mem[row];
            if (we) begin
                mem[row] <= wdata;
            end
        end
    end

endmodule

// File: rtl/scb_bank_grant.sv
// Chooses which pending lanes a bank serves this cycle: the lowest-numbered
// matching lane normally, or every matching lane in a broadcast group.
module scb_bank_grant #(
    parameter int NUM_LANES = 16,
    parameter int BANK_W    = 4,
    parameter int BANK_ID   = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES-1:0]          pending,
    input  logic [NUM_LANES*BANK_W-1:0]   lane_bank,
    input  logic                          bcast,
    output logic [NUM_LANES-1:0]          grant
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    logic [NUM_LANES-1:0] match;
    logic                 taken;

    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            match[l] = pending[l] && (lane_bank[l*BANK_W +: BANK_W] == MY_BANK);
        end
    end

    always_comb begin
        grant = '0;
        taken = 1'b0;
        if (bcast) begin
            grant = match;
        end else begin
            for (int l = 0; l < NUM_LANES; l++) begin
                if (match[l] && !taken) begin
                    grant[l] = 1'b1;
                    taken    = 1'b1;
                end
            end
        end
    end

    // R4: outside broadcast, a bank never serves two lanes in one cycle
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !bcast |-> $onehot0(grant));

    // R4: a granted lane must be pending and belong to this bank
    a_r4_grant_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~match) == '0);

endmodule

// File: rtl/scb_bcast_detect.sv
// Flags a group whose enabled lanes all carry one identical address.
module scb_bcast_detect #(
    parameter int NUM_LANES = 16,
    parameter int ADDR_W    = 10
) (
    input  logic [NUM_LANES-1:0]        lane_en,
    input  logic [NUM_LANES*ADDR_W-1:0] addr,
    output logic                        bcast
);
    logic [ADDR_W-1:0] ref_addr;
    logic              found;
    logic              all_same;

    always_comb begin
        ref_addr = '0;
        found    = 1'b0;
        all_same = 1'b1;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (lane_en[l]) begin
                if (!found) begin
                    ref_addr = addr[l*ADDR_W +: ADDR_W];
                    found    = 1'b1;
                end else if (addr[l*ADDR_W +: ADDR_W] != ref_addr) begin
                    all_same = 1'b0;
                end
            end
        end
        bcast = found && all_same;
    end

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
    import scb_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int NUM_BANKS = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int CNT_W     = $clog2(NUM_LANES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [NUM_LANES-1:0]           req_lane_en,
    input  logic [NUM_LANES*ADDR_W-1:0]    req_addr,
    input  logic [NUM_LANES-1:0]           req_wr,
    input  logic [NUM_LANES*DATA_W-1:0]    req_wdata,
    output logic                           done,
    output logic [NUM_LANES*DATA_W-1:0]    rsp_rdata,
    output logic [CNT_W-1:0]               rsp_cycles
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    // ---------------- control state ----------------
    sched_state_t state_q, state_d;

    logic                  accept;
    logic                  issuing;
    logic                  bcast_in;
    logic                  bcast_q;
    logic [NUM_LANES-1:0]  lane_en_q;
    logic [NUM_LANES-1:0]  wr_q;
    logic [NUM_LANES-1:0]  pending_q;
    logic [NUM_LANES-1:0]  pend_issue;
    logic [NUM_LANES-1:0]  served_all;
    logic [NUM_LANES-1:0]  served_d1;
    logic [ADDR_W-1:0]     addr_q  [NUM_LANES];
    logic [DATA_W-1:0]     wdata_q [NUM_LANES];
    logic [DATA_W-1:0]     rdata_q [NUM_LANES];
    logic [DATA_W-1:0]     bank_q  [NUM_BANKS];
    logic [NUM_LANES-1:0]  grant_arr [NUM_BANKS];
    logic [NUM_LANES*BANK_W-1:0] lane_bank_flat;
    logic [CNT_W-1:0]      count_q;
    logic                  done_q;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign issuing    = (state_q == ST_ISSUE);
    assign pend_issue = issuing ? pending_q : '0;

    scb_bcast_detect #(
        .NUM_LANES (NUM_LANES),
        .ADDR_W    (ADDR_W)
    ) u_bcast (
        .lane_en (req_lane_en),
        .addr    (req_addr),
        .bcast   (bcast_in)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (|req_lane_en) ? ST_ISSUE : ST_FINISH;
                end
            end
            ST_ISSUE: begin
                if ((pending_q & ~served_all) == '0) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- per-lane bank index ----------------
    for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane_bank
        assign lane_bank_flat[gl*BANK_W +: BANK_W] = addr_q[gl][BANK_W-1:0];
    end

    // ---------------- banks ----------------
    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        logic [NUM_LANES-1:0] gnt;
        logic [ROW_W-1:0]     row;
        logic                 we;
        logic [DATA_W-1:0]    wd;

        scb_bank_grant #(
            .NUM_LANES (NUM_LANES),
            .BANK_W    (BANK_W),
            .BANK_ID   (gb)
        ) u_grant (
            .clk       (clk),
            .rst_n     (rst_n),
            .pending   (pend_issue),
            .lane_bank (lane_bank_flat),
            .bcast     (bcast_q),
            .grant     (gnt)
        );

        // Address from any granted lane (all equal in broadcast); the
        // highest granted writer supplies the data.
        always_comb begin
            row = '0;
            we  = 1'b0;
            wd  = '0;
            for (int l = 0; l < NUM_LANES; l++) begin
                if (gnt[l]) begin
                    row = addr_q[l][ADDR_W-1:BANK_W];
                    if (wr_q[l]) begin
                        we = 1'b1;
                        wd = wdata_q[l];
                    end
                end
            end
        end

        scb_bank #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W)
        ) u_ram (
            .clk   (clk),
            .en    (|gnt),
            .we    (we),
            .row   (row),
            .wdata (wd),
            .rdata (bank_q[gb])
        );

        assign grant_arr[gb] = gnt;
    end

    always_comb begin
        served_all = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            served_all = served_all | grant_arr[b];
        end
    end

    // ---------------- datapath / outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_en_q <= '0;
            wr_q      <= '0;
            pending_q <= '0;
            bcast_q   <= 1'b0;
            count_q   <= '0;
            served_d1 <= '0;
            done_q    <= 1'b0;
            for (int l = 0; l < NUM_LANES; l++) begin
                addr_q[l]  <= '0;
                wdata_q[l] <= '0;
                rdata_q[l] <= '0;
            end
        end else begin
            served_d1 <= served_all;
            done_q    <= (state_q == ST_FINISH);
            if (accept) begin
                lane_en_q <= req_lane_en;
                wr_q      <= req_wr & req_lane_en;
                pending_q <= req_lane_en;
                bcast_q   <= bcast_in;
                count_q   <= '0;
                for (int l = 0; l < NUM_LANES; l++) begin
                    addr_q[l]  <= req_addr[l*ADDR_W +: ADDR_W];
                    wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
                    rdata_q[l] <= '0;
                end
            end else begin
                if (issuing) begin
                    pending_q <= pending_q & ~served_all;
                    count_q   <= count_q + CNT_W'(1);
                end
                for (int l = 0; l < NUM_LANES; l++) begin
                    if (served_d1[l]) begin
                        rdata_q[l] <= bank_q[addr_q[l][BANK_W-1:0]];
                    end
                end
            end
        end
    end

    assign done       = done_q;
    assign rsp_cycles = count_q;

    for (genvar go = 0; go < NUM_LANES; go++) begin : g_out
        assign rsp_rdata[go*DATA_W +: DATA_W] = rdata_q[go];
    end

    // ---------------- assertions ----------------
    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the captured group does not change while the block is busy
    a_r2_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(lane_en_q) && $stable(wr_q)));

    // R4: every service cycle retires at least one pending lane
    a_r4_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE) |=> ($countones(pending_q) < $past($countones(pending_q))));

    // R5: a broadcast group spends exactly one cycle in service
    a_r5_bcast_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && bcast_q) |=> (state_q == ST_FINISH));

    // R6: disabled lanes are never pending
    a_r6_pending_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q & ~lane_en_q) == '0);

    // R7: done only follows the finishing state
    a_r7_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == ST_FINISH));

endmodule

// File: tb/bank_conflict_serializer_tb.sv
module bank_conflict_serializer_tb;
    localparam int NL    = 16;
    localparam int DW    = 32;
    localparam int AW    = 10;
    localparam int CW    = 5;
    localparam int WORDS = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [NL-1:0]     req_lane_en = '0;
    logic [NL*AW-1:0]  req_addr = '0;
    logic [NL-1:0]     req_wr = '0;
    logic [NL*DW-1:0]  req_wdata = '0;
    logic              done;
    logic [NL*DW-1:0]  rsp_rdata;
    logic [CW-1:0]     rsp_cycles;

    int checks = 0;
    int failures = 0;

    // group under test and reference model
    logic          g_en    [NL];
    logic [AW-1:0] g_addr  [NL];
    logic          g_wr    [NL];
    logic [DW-1:0] g_wdata [NL];
    logic [DW-1:0] exp_rd  [NL];
    logic [DW-1:0] mem     [WORDS];

    always #2 clk = ~clk;

    bank_conflict_serializer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_lane_en (req_lane_en),
        .req_addr    (req_addr),
        .req_wr      (req_wr),
        .req_wdata   (req_wdata),
        .done        (done),
        .rsp_rdata   (rsp_rdata),
        .rsp_cycles  (rsp_cycles)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit f_is_bcast();
        bit found = 0;
        bit same = 1;
        logic [AW-1:0] r = '0;
        for (int l = 0; l < NL; l++) begin
            if (g_en[l]) begin
                if (!found) begin r = g_addr[l]; found = 1; end
                else if (g_addr[l] != r) same = 0;
            end
        end
        return found && same;
    endfunction

    function automatic int f_expected_cycles();
        int per_bank [NL];
        int mx = 0;
        bit any = 0;
        for (int b = 0; b < NL; b++) per_bank[b] = 0;
        for (int l = 0; l < NL; l++) begin
            if (g_en[l]) begin
                per_bank[g_addr[l] % 16]++;
                any = 1;
            end
        end
        if (!any) return 0;
        if (f_is_bcast()) return 1;
        for (int b = 0; b < NL; b++) if (per_bank[b] > mx) mx = per_bank[b];
        return mx;
    endfunction

    // Computes expected read words and advances the model memory.
    task automatic model_group();
        if (f_is_bcast()) begin
            logic [AW-1:0] a = '0;
            for (int l = 0; l < NL; l++) if (g_en[l]) a = g_addr[l];
            for (int l = 0; l < NL; l++) exp_rd[l] = g_en[l] ? mem[a] : '0;
            for (int l = 0; l < NL; l++) if (g_en[l] && g_wr[l]) mem[a] = g_wdata[l];
        end else begin
            for (int l = 0; l < NL; l++) begin
                exp_rd[l] = '0;
                if (g_en[l]) begin
                    exp_rd[l] = mem[g_addr[l]];
                    if (g_wr[l]) mem[g_addr[l]] = g_wdata[l];
                end
            end
        end
    endtask

    task automatic run_group(input string rq);
        int ec;
        int n;
        ec = f_expected_cycles();
        model_group();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        for (int l = 0; l < NL; l++) begin
            req_lane_en[l]            = g_en[l];
            req_addr[l*AW +: AW]      = g_addr[l];
            req_wr[l]                 = g_wr[l];
            req_wdata[l*DW +: DW]     = g_wdata[l];
        end
        @(posedge clk);
        #1;
        req_valid   = 1'b0;
        req_lane_en = NL'($urandom);
        req_wr      = NL'($urandom);
        for (int l = 0; l < NL; l++) begin
            req_addr[l*AW +: AW]  = AW'($urandom);
            req_wdata[l*DW +: DW] = $urandom;
        end
        check(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
        n = 0;
        while (!done && n < 100) begin
            @(posedge clk);
            #1;
            n++;
        end
        check(n == ec + 1, "R7", "edges from accept to done", n, ec + 1);
        check(int'(rsp_cycles) == ec, rq, "cycle count", rsp_cycles, ec);
        for (int l = 0; l < NL; l++) begin
            check(rsp_rdata[l*DW +: DW] === exp_rd[l], rq, $sformatf("lane %0d read word", l),
                  rsp_rdata[l*DW +: DW], exp_rd[l]);
        end
        @(posedge clk);
        #1;
        check(done == 1'b0, "R7", "done is one cycle", done, 0);
    endtask

    task automatic clear_group();
        for (int l = 0; l < NL; l++) begin
            g_en[l] = 1'b0; g_addr[l] = '0; g_wr[l] = 1'b0; g_wdata[l] = '0;
        end
    endtask

    task automatic stride_group(input int base, input int s, input string rq);
        clear_group();
        for (int l = 0; l < NL; l++) begin
            g_en[l] = 1'b1;
            g_addr[l] = AW'(base + s * l);
        end
        run_group(rq);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        check(done == 1'b0, "R10", "done after reset", done, 0);
        check(rsp_cycles == '0, "R10", "cycles after reset", rsp_cycles, 0);
        check(rsp_rdata == '0, "R10", "rdata after reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill the whole scratchpad with consecutive conflict-free writes (R3)
        for (int g = 0; g < WORDS / NL; g++) begin
            for (int l = 0; l < NL; l++) begin
                g_en[l] = 1'b1; g_addr[l] = AW'(g * NL + l);
                g_wr[l] = 1'b1; g_wdata[l] = $urandom;
                mem[g * NL + l] = 'x;
            end
            for (int l = 0; l < NL; l++) mem[g * NL + l] = '0;
            if (g == 0) begin
                // first write group: reads are don't-care, compare with memory state only
                for (int l = 0; l < NL; l++) mem[l] = 'x;
            end
            run_group_fill();
        end

        // R9: stride patterns
        stride_group(5, 3, "R9");
        stride_group(0, 2, "R9");
        stride_group(7, 4, "R9");
        stride_group(1, 16, "R9");
        stride_group(9, 1, "R3");

        // R1: distinct low bits, random upper bits
        clear_group();
        for (int l = 0; l < NL; l++) begin
            g_en[l] = 1'b1;
            g_addr[l] = {6'($urandom), 4'(l)};
        end
        run_group("R1");

        // R4: lower lane writes a word that a higher lane reads in the same bank
        clear_group();
        g_en[0] = 1; g_addr[0] = 10'd32; g_wr[0] = 1; g_wdata[0] = 32'hCAFE_0001;
        g_en[1] = 1; g_addr[1] = 10'd32;
        g_en[2] = 1; g_addr[2] = 10'd48;
        g_en[5] = 1; g_addr[5] = 10'd5;
        run_group("R4");

        // R8: read-first on a lane that writes
        clear_group();
        g_en[3] = 1; g_addr[3] = 10'd100; g_wr[3] = 1; g_wdata[3] = 32'h1234_5678;
        g_en[4] = 1; g_addr[4] = 10'd101;
        run_group("R8");

        // R5: full broadcast with two writers
        clear_group();
        for (int l = 0; l < NL; l++) begin g_en[l] = 1; g_addr[l] = 10'd77; end
        g_wr[3] = 1; g_wdata[3] = 32'hAAAA_0003;
        g_wr[9] = 1; g_wdata[9] = 32'hBBBB_0009;
        run_group("R5");
        clear_group();
        g_en[0] = 1; g_addr[0] = 10'd77;
        g_en[1] = 1; g_addr[1] = 10'd93;
        run_group("R5");

        // R5/R6: broadcast over a sparse lane set
        clear_group();
        for (int l = 0; l < NL; l += 2) begin g_en[l] = 1; g_addr[l] = 10'd200; end
        g_wr[14] = 1; g_wdata[14] = 32'hDEAD_BEEF;
        run_group("R5");

        // R6: empty group
        clear_group();
        run_group("R6");

        // R6: disabled lanes parked on the busy bank do not add conflicts
        clear_group();
        for (int l = 0; l < NL; l++) begin g_addr[l] = AW'(l * 16); end
        g_en[4] = 1; g_en[8] = 1;
        run_group("R6");

        // R4: random collision-heavy groups
        for (int i = 0; i < 300; i++) begin
            int msk;
            msk = (i % 3 == 0) ? 10'h3FF : ((i % 3 == 1) ? 10'h03F : 10'h033);
            for (int l = 0; l < NL; l++) begin
                g_en[l]    = ($urandom % 4) != 0;
                g_addr[l]  = AW'($urandom & msk);
                g_wr[l]    = ($urandom % 3) == 0;
                g_wdata[l] = $urandom;
            end
            run_group("R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Fill groups: only count and latency are checked, since the prior
    // content of freshly powered banks is unknown.
    task automatic run_group_fill();
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        for (int l = 0; l < NL; l++) begin
            req_lane_en[l]        = g_en[l];
            req_addr[l*AW +: AW]  = g_addr[l];
            req_wr[l]             = g_wr[l];
            req_wdata[l*DW +: DW] = g_wdata[l];
            mem[g_addr[l]]        = g_wdata[l];
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            @(posedge clk);
            #1;
            n++;
        end
        check(n == 2, "R7", "fill latency", n, 2);
        check(rsp_cycles == CW'(1), "R3", "fill cycle count", rsp_cycles, 1);
    endtask

endmodule